// File: doc/BRIEF.md
# Ethernet Receive Traffic Monitor

This block sits on the receive side of a serial-link test setup. It watches a beat-wide packet stream in which a valid strobe qualifies each beat, start and end markers frame the packets, and an empty field gives the unused bytes of the last beat. A six-bit error vector comes with each beat. From this stream the monitor keeps statistics: a count of all packets, a count of clean packets, a count of errored packets, a running byte total, and a sticky record of the error causes it has seen.

Software reads the statistics over a simple internal register bus with 16-bit addresses. A read strobe returns data one cycle later with a valid flag. The same bus writes a loopback-enable bit, which leaves the block as a port, and carries the generator start command, which clears all statistics. The almost-empty and almost-full flags of an external loopback FIFO come in as inputs and can be read back as a status word. The byte total is wider than a bus word, so it is read in two halves. Reading the low half captures the high half at the same moment, so the two reads always describe one value.

Top module: `ethrx_traffic_mon`

## Requirements
- R1: After reset every statistic register reads zero, `lpbk_en` is 0 and `reg_rd_valid` is 0.
- R2: A beat is accepted only when `rx_valid` is high and either `rx_sop` is high or a packet is open. A packet stays open from its start beat until its end beat. Valid beats outside a packet that lack `rx_sop` change no statistic. A start beat inside an open packet drops the open packet without counting it and opens a new one. Bytes of every accepted beat are still counted.
- R3: At an accepted end beat the packet counts as errored if any bit of `rx_err` is set on that beat, and as clean otherwise. Error bits on beats other than the end beat are ignored. Address 0x3d00 reads the total, 0x3d01 the clean count and 0x3d02 the errored count. The total always equals clean plus errored, modulo the counter width.
- R4: Each accepted beat that is not an end beat adds BEAT_BYTES to the byte total, and its `rx_empty` is ignored. An accepted end beat adds BEAT_BYTES minus `rx_empty`.
- R5: The error word at 0x3d07 holds sticky cause bits that are OR-ed in from `rx_err` of errored end beats: `rx_err[5]` overflow to bit 9, `[4]` length to bit 8, `[3]` oversize to bit 7, `[2]` undersize to bit 6, `[1]` CRC to bit 5 and `[0]` PHY to bit 4. Bit 3 is set once any cause has been captured. All other bits read zero.
- R6: A write to 0x3c03 with data bit 0 set clears every packet counter, the byte total and the error word in the cycle it is accepted, and it overrides any update in that cycle. The same write with bit 0 clear has no effect. The loopback enable is not touched.
- R7: A read of 0x3d03 returns the low REG_W bits of the byte total and captures the upper bits of the total. A read of 0x3d04 returns the captured upper bits, even if the total has since carried into them.
- R8: A write to 0x3e00 sets `lpbk_en` to data bit 0. The bit reads back at 0x3e00 bit 0. No other access changes it.
- R9: Address 0x3e01 reads `fifo_almost_empty` in bit 1 and `fifo_almost_full` in bit 0, with all other bits zero.
- R10: `reg_rd_valid` is high exactly in the cycle after `reg_rd_en`, with `reg_rdata` valid in that same cycle. Unmapped addresses read zero. Writes to the statistic addresses have no effect.
- R11: The packet counters are CNT_W bits wide, wrap modulo 2^CNT_W, and read zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Beat qualifier |
| rx_sop | input | 1 | First beat of a packet |
| rx_eop | input | 1 | Last beat of a packet |
| rx_empty | input | EMPTY_W | Unused bytes in the last beat |
| rx_err | input | 6 | Per-beat error causes {overflow, length, oversize, undersize, CRC, PHY} |
| fifo_almost_empty | input | 1 | Loopback FIFO almost-empty flag |
| fifo_almost_full | input | 1 | Loopback FIFO almost-full flag |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid with reg_rd_valid |
| reg_rd_valid | output | 1 | Read response strobe |
| lpbk_en | output | 1 | Loopback enable control |

## Verification
The bench builds the monitor with BEAT_BYTES=64, CNT_W=8, BYTE_CNT_W=32 and REG_W=16. The 8-bit packet counters let a few hundred random packets wrap them. Because the byte total is split at bit 16, the same traffic carries into the upper half, and a single long packet sent between the low and the high read shows whether the captured half stays frozen. The 64-byte beat gives a six-bit empty field, so random end-beat lengths cover the full range of partial beats.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

    localparam int REG_ADDR_W = 16;

    // register map
    localparam logic [REG_ADDR_W-1:0] A_GEN_START = 16'h3C03;
    localparam logic [REG_ADDR_W-1:0] A_PKT_ALL   = 16'h3D00;
    localparam logic [REG_ADDR_W-1:0] A_PKT_OK    = 16'h3D01;
    localparam logic [REG_ADDR_W-1:0] A_PKT_BAD   = 16'h3D02;
    localparam logic [REG_ADDR_W-1:0] A_BYTES_LO  = 16'h3D03;
    localparam logic [REG_ADDR_W-1:0] A_BYTES_HI  = 16'h3D04;
    localparam logic [REG_ADDR_W-1:0] A_RX_ERR    = 16'h3D07;
    localparam logic [REG_ADDR_W-1:0] A_LOOP_CTL  = 16'h3E00;
    localparam logic [REG_ADDR_W-1:0] A_LOOP_FIFO = 16'h3E01;

    // error word layout: causes occupy [ERR_CAUSE_LSB +: N_CAUSE]
    localparam int N_CAUSE       = 6;
    localparam int ERR_VLD_BIT   = 3;
    localparam int ERR_CAUSE_LSB = 4;
    localparam int ERR_WORD_MSB  = ERR_CAUSE_LSB + N_CAUSE - 1;

    // loopback FIFO status layout
    localparam int FIFO_AE_BIT = 1;
    localparam int FIFO_AF_BIT = 0;

    typedef logic [N_CAUSE-1:0] cause_t;

endpackage

// File: rtl/rtm_pkt_tracker.sv
// Frames the beat stream into packets and emits one registered event per
// accepted beat: its byte contribution, and on the last beat the verdict.
module rtm_pkt_tracker
    import rtm_pkg::*;
#(
    parameter int BEAT_BYTES = 8,
    parameter int EMPTY_W    = 3,
    parameter int NB_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    input  cause_t             in_err,
    output logic               ev_beat,
    output logic               ev_last,
    output logic               ev_bad,
    output cause_t             ev_cause,
    output logic [NB_W-1:0]    ev_nbytes
);

    typedef struct packed {
        logic            in_pkt;
        logic            beat;
        logic            last;
        logic            bad;
        cause_t          cause;
        logic [NB_W-1:0] nbytes;
    } trk_t;

    trk_t trk_d, trk_q;
    logic accept;

    always_comb begin
        trk_d        = trk_q;
        trk_d.beat   = 1'b0;
        trk_d.last   = 1'b0;
        trk_d.bad    = 1'b0;
        trk_d.cause  = '0;
        trk_d.nbytes = '0;
        accept       = in_valid && (in_sop || trk_q.in_pkt);
        if (accept) begin
            trk_d.beat   = 1'b1;
            trk_d.in_pkt = !in_eop;
            if (in_eop) begin
                trk_d.last   = 1'b1;
                trk_d.bad    = |in_err;
                trk_d.cause  = in_err;
                trk_d.nbytes = NB_W'(BEAT_BYTES) - NB_W'(in_empty);
            end else begin
                trk_d.nbytes = NB_W'(BEAT_BYTES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign ev_beat   = trk_q.beat;
    assign ev_last   = trk_q.last;
    assign ev_bad    = trk_q.bad;
    assign ev_cause  = trk_q.cause;
    assign ev_nbytes = trk_q.nbytes;

endmodule

// File: rtl/rtm_stats.sv
// Packet counters, byte total and sticky error capture.
module rtm_stats
    import rtm_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int BYTE_CNT_W = 64,
    parameter int NB_W       = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  ev_beat,
    input  logic                  ev_last,
    input  logic                  ev_bad,
    input  cause_t                ev_cause,
    input  logic [NB_W-1:0]       ev_nbytes,
    output logic [CNT_W-1:0]      cnt_all,
    output logic [CNT_W-1:0]      cnt_ok,
    output logic [CNT_W-1:0]      cnt_bad,
    output logic [BYTE_CNT_W-1:0] byte_cnt,
    output cause_t                err_cause,
    output logic                  err_vld
);

    typedef struct packed {
        logic [CNT_W-1:0]      all;
        logic [CNT_W-1:0]      ok;
        logic [CNT_W-1:0]      bad;
        logic [BYTE_CNT_W-1:0] bytes;
        cause_t                cause;
        logic                  vld;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ev_beat) begin
            st_d.bytes = st_q.bytes + BYTE_CNT_W'(ev_nbytes);
        end
        if (ev_last) begin
            st_d.all = st_q.all + 1'b1;
            if (ev_bad) begin
                st_d.bad   = st_q.bad + 1'b1;
                st_d.cause = st_q.cause | ev_cause;
                st_d.vld   = 1'b1;
            end else begin
                st_d.ok = st_q.ok + 1'b1;
            end
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_all   = st_q.all;
    assign cnt_ok    = st_q.ok;
    assign cnt_bad   = st_q.bad;
    assign byte_cnt  = st_q.bytes;
    assign err_cause = st_q.cause;
    assign err_vld   = st_q.vld;

endmodule

// File: rtl/rtm_regs.sv
// Register decode: read mux with one-cycle response, loopback control,
// statistics clear strobe and the high-half capture of the byte total.
module rtm_regs
    import rtm_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int BYTE_CNT_W = 64,
    parameter int REG_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]      wdata,
    input  logic [CNT_W-1:0]      cnt_all,
    input  logic [CNT_W-1:0]      cnt_ok,
    input  logic [CNT_W-1:0]      cnt_bad,
    input  logic [BYTE_CNT_W-1:0] byte_cnt,
    input  cause_t                err_cause,
    input  logic                  err_vld,
    input  logic                  fifo_ae,
    input  logic                  fifo_af,
    output logic [REG_W-1:0]      rdata,
    output logic                  rd_valid,
    output logic                  loop_en,
    output logic                  stat_clr
);

    localparam int DW2 = 2 * REG_W;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
        logic             rd_valid;
        logic             loop_en;
        logic [REG_W-1:0] hi_shadow;
    } rg_t;

    rg_t rg_d, rg_q;

    logic [DW2-1:0]   byte_ext;
    logic [REG_W-1:0] err_word;
    logic [REG_W-1:0] fifo_word;
    logic             unused_wdata;

    assign byte_ext     = DW2'(byte_cnt);
    assign unused_wdata = ^wdata[REG_W-1:1];

    always_comb begin
        err_word = '0;
        err_word[ERR_CAUSE_LSB +: N_CAUSE] = err_cause;
        err_word[ERR_VLD_BIT] = err_vld;
        fifo_word = '0;
        fifo_word[FIFO_AE_BIT] = fifo_ae;
        fifo_word[FIFO_AF_BIT] = fifo_af;
    end

    assign stat_clr = wr_en && (addr == A_GEN_START) && wdata[0];

    always_comb begin
        rg_d          = rg_q;
        rg_d.rd_valid = rd_en;
        rg_d.rdata    = '0;
        if (wr_en && (addr == A_LOOP_CTL)) begin
            rg_d.loop_en = wdata[0];
        end
        if (rd_en) begin
            case (addr)
                A_PKT_ALL:   rg_d.rdata = REG_W'(cnt_all);
                A_PKT_OK:    rg_d.rdata = REG_W'(cnt_ok);
                A_PKT_BAD:   rg_d.rdata = REG_W'(cnt_bad);
                A_BYTES_LO: begin
                    rg_d.rdata     = byte_ext[REG_W-1:0];
                    rg_d.hi_shadow = byte_ext[DW2-1:REG_W];
                end
                A_BYTES_HI:  rg_d.rdata = rg_q.hi_shadow;
                A_RX_ERR:    rg_d.rdata = err_word;
                A_LOOP_CTL:  rg_d.rdata = REG_W'(rg_q.loop_en);
                A_LOOP_FIFO: rg_d.rdata = fifo_word;
                default:     rg_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign rdata    = rg_q.rdata;
    assign rd_valid = rg_q.rd_valid;
    assign loop_en  = rg_q.loop_en;

endmodule

// File: rtl/ethrx_traffic_mon.sv
module ethrx_traffic_mon
    import rtm_pkg::*;
#(
    parameter  int BEAT_BYTES = 8,
    parameter  int CNT_W      = 32,
    parameter  int BYTE_CNT_W = 64,
    parameter  int REG_W      = 32,
    localparam int EMPTY_W    = $clog2(BEAT_BYTES),
    localparam int NB_W       = $clog2(BEAT_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic                  rx_sop,
    input  logic                  rx_eop,
    input  logic [EMPTY_W-1:0]    rx_empty,
    input  logic [N_CAUSE-1:0]    rx_err,
    input  logic                  fifo_almost_empty,
    input  logic                  fifo_almost_full,
    input  logic                  reg_wr_en,
    input  logic                  reg_rd_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  reg_rd_valid,
    output logic                  lpbk_en
);

    logic                  ev_beat, ev_last, ev_bad;
    cause_t                ev_cause;
    logic [NB_W-1:0]       ev_nbytes;
    logic                  stat_clr;
    logic [CNT_W-1:0]      cnt_all, cnt_ok, cnt_bad;
    logic [BYTE_CNT_W-1:0] byte_cnt;
    cause_t                err_cause;
    logic                  err_vld;

    rtm_pkt_tracker #(
        .BEAT_BYTES(BEAT_BYTES),
        .EMPTY_W   (EMPTY_W),
        .NB_W      (NB_W)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_sop   (rx_sop),
        .in_eop   (rx_eop),
        .in_empty (rx_empty),
        .in_err   (rx_err),
        .ev_beat  (ev_beat),
        .ev_last  (ev_last),
        .ev_bad   (ev_bad),
        .ev_cause (ev_cause),
        .ev_nbytes(ev_nbytes)
    );

    rtm_stats #(
        .CNT_W     (CNT_W),
        .BYTE_CNT_W(BYTE_CNT_W),
        .NB_W      (NB_W)
    ) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (stat_clr),
        .ev_beat  (ev_beat),
        .ev_last  (ev_last),
        .ev_bad   (ev_bad),
        .ev_cause (ev_cause),
        .ev_nbytes(ev_nbytes),
        .cnt_all  (cnt_all),
        .cnt_ok   (cnt_ok),
        .cnt_bad  (cnt_bad),
        .byte_cnt (byte_cnt),
        .err_cause(err_cause),
        .err_vld  (err_vld)
    );

    rtm_regs #(
        .CNT_W     (CNT_W),
        .BYTE_CNT_W(BYTE_CNT_W),
        .REG_W     (REG_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (reg_rd_en),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cnt_all  (cnt_all),
        .cnt_ok   (cnt_ok),
        .cnt_bad  (cnt_bad),
        .byte_cnt (byte_cnt),
        .err_cause(err_cause),
        .err_vld  (err_vld),
        .fifo_ae  (fifo_almost_empty),
        .fifo_af  (fifo_almost_full),
        .rdata    (reg_rdata),
        .rd_valid (reg_rd_valid),
        .loop_en  (lpbk_en),
        .stat_clr (stat_clr)
    );

endmodule

// File: rtl/rtm_checker.sv
module rtm_checker
    import rtm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_rd_en,
    input logic                  reg_rd_valid,
    input logic                  reg_wr_en,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic                  lpbk_en,
    input logic                  stat_clr,
    input logic [CNT_W-1:0]      cnt_all,
    input logic [CNT_W-1:0]      cnt_ok,
    input logic [CNT_W-1:0]      cnt_bad,
    input cause_t                err_cause,
    input logic                  err_vld
);

    AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> reg_rd_valid); // R10

    AST_NO_SPURIOUS_RDV: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_valid |-> $past(reg_rd_en)); // R10

    AST_TOTAL_IS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_all == CNT_W'(cnt_ok + cnt_bad)); // R3

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr |=> ((err_cause & $past(err_cause)) == $past(err_cause))); // R5

    AST_VALID_TRACKS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld == (|err_cause)); // R5

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (cnt_all == '0 && cnt_ok == '0 && cnt_bad == '0 && !err_vld)); // R6

    AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == A_LOOP_CTL) |=> $stable(lpbk_en)); // R8

endmodule

bind ethrx_traffic_mon rtm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rd_en   (reg_rd_en),
    .reg_rd_valid(reg_rd_valid),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .lpbk_en     (lpbk_en),
    .stat_clr    (stat_clr),
    .cnt_all     (cnt_all),
    .cnt_ok      (cnt_ok),
    .cnt_bad     (cnt_bad),
    .err_cause   (err_cause),
    .err_vld     (err_vld)
);

// File: tb/sim_ethrx_traffic_mon.sv
`timescale 1ns/1ps
module sim_ethrx_traffic_mon;

    localparam int BB    = 64;
    localparam int CW    = 8;
    localparam int BCW   = 32;
    localparam int RW    = 16;
    localparam int EW    = $clog2(BB);

    localparam logic [15:0] R_START = 16'h3C03;
    localparam logic [15:0] R_ALL   = 16'h3D00;
    localparam logic [15:0] R_OK    = 16'h3D01;
    localparam logic [15:0] R_BAD   = 16'h3D02;
    localparam logic [15:0] R_BLO   = 16'h3D03;
    localparam logic [15:0] R_BHI   = 16'h3D04;
    localparam logic [15:0] R_ERR   = 16'h3D07;
    localparam logic [15:0] R_LOOP  = 16'h3E00;
    localparam logic [15:0] R_FIFO  = 16'h3E01;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [EW-1:0] rx_empty = '0;
    logic [5:0]    rx_err = '0;
    logic          fifo_ae = 1'b0, fifo_af = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0]   addr = '0;
    logic [RW-1:0] wdata = '0;
    logic [RW-1:0] rdata;
    logic          rd_valid;
    logic          lpbk_en;

    int n_checks = 0;
    int n_errors = 0;

    // expected model
    int          exp_all = 0, exp_ok = 0, exp_bad = 0;
    logic [31:0] exp_bytes = '0;
    logic [5:0]  exp_cause = '0;

    always #2 clk = ~clk;

    ethrx_traffic_mon #(
        .BEAT_BYTES(BB), .CNT_W(CW), .BYTE_CNT_W(BCW), .REG_W(RW)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .rx_empty(rx_empty), .rx_err(rx_err),
        .fifo_almost_empty(fifo_ae), .fifo_almost_full(fifo_af),
        .reg_wr_en(wr_en), .reg_rd_en(rd_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .reg_rd_valid(rd_valid),
        .lpbk_en(lpbk_en)
    );

    function automatic logic [RW-1:0] err_word_of(input logic [5:0] c);
        logic [RW-1:0] w;
        w = '0;
        w[9:4] = c;
        w[3] = |c;
        return w;
    endfunction

    function automatic logic [RW-1:0] cnt_of(input int v);
        return RW'(v % (1 << CW));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [RW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check("R10 rd_valid", 32'(rd_valid), 32'd1);
        d = rdata;
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [RW-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_err = '0;
        end
    endtask

    task automatic beat(input logic s, input logic e, input logic [EW-1:0] emp, input logic [5:0] er);
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = s; rx_eop = e; rx_empty = emp; rx_err = er;
    endtask

    // complete packet; noise puts random error bits on non-final beats
    task automatic send_pkt(input int nb, input logic [EW-1:0] emp, input logic [5:0] eop_err, input logic noise);
        for (int b = 0; b < nb; b++) begin
            if (b == nb - 1) beat(b == 0, 1'b1, emp, eop_err);
            else             beat(b == 0, 1'b0, EW'($urandom), noise ? 6'($urandom) : 6'd0);
        end
        exp_all++;
        if (|eop_err) exp_bad++; else exp_ok++;
        exp_cause = exp_cause | eop_err;
        exp_bytes = exp_bytes + 32'(BB * (nb - 1)) + 32'(BB) - 32'(emp);
    endtask

    task automatic check_stats(input string tag);
        logic [RW-1:0] d;
        reg_read(R_ALL, d); check({tag, " R3 R11 total"}, 32'(d), 32'(cnt_of(exp_all)));
        reg_read(R_OK,  d); check({tag, " R3 R11 clean"}, 32'(d), 32'(cnt_of(exp_ok)));
        reg_read(R_BAD, d); check({tag, " R3 R11 errored"}, 32'(d), 32'(cnt_of(exp_bad)));
        reg_read(R_BLO, d); check({tag, " R4 bytes lo"}, 32'(d), 32'(exp_bytes[15:0]));
        reg_read(R_BHI, d); check({tag, " R7 bytes hi"}, 32'(d), 32'(exp_bytes[31:16]));
        reg_read(R_ERR, d); check({tag, " R5 err word"}, 32'(d), 32'(err_word_of(exp_cause)));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [RW-1:0] d, hi_old;
        void'($urandom(32'd715));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 lpbk_en", 32'(lpbk_en), 32'd0);
        check_stats("R1 reset");
        reg_read(R_LOOP, d); check("R1 loop reg", 32'(d), 32'd0);

        // R9 FIFO status
        for (int k = 0; k < 4; k++) begin
            fifo_ae = k[1]; fifo_af = k[0];
            reg_read(R_FIFO, d);
            check("R9 fifo status", 32'(d), 32'(k));
        end

        // R8 loopback control
        reg_write(R_LOOP, 16'h0001);
        check("R8 lpbk_en set", 32'(lpbk_en), 32'd1);
        reg_read(R_LOOP, d); check("R8 loop readback", 32'(d), 32'd1);
        reg_write(R_LOOP, 16'hFFFE);
        check("R8 lpbk_en clear", 32'(lpbk_en), 32'd0);
        reg_write(R_LOOP, 16'h0001);

        // R10 unmapped and read-only
        reg_read(16'h1234, d); check("R10 unmapped", 32'(d), 32'd0);
        reg_write(R_OK, 16'h0055);
        reg_read(R_OK, d); check("R10 write to counter ignored", 32'(d), 32'd0);

        // R4 single beat partial
        send_pkt(1, EW'(3), 6'd0, 1'b0); idle(3);
        check_stats("R4 single");

        // R2 stray beat outside a packet
        beat(1'b0, 1'b1, EW'(0), 6'h3F); idle(3);
        check_stats("R2 stray");

        // R2 start inside open packet drops the open one
        beat(1'b1, 1'b0, EW'(5), 6'd0);
        beat(1'b1, 1'b1, EW'(10), 6'd0);
        idle(3);
        exp_all++; exp_ok++;
        exp_bytes = exp_bytes + 32'(BB) + 32'(BB - 10);
        check_stats("R2 restart");

        // R5 CRC cause on end beat
        send_pkt(2, EW'(0), 6'b000010, 1'b0); idle(3);
        reg_read(R_ERR, d); check("R5 crc bit5+valid", 32'(d), 32'h0028);
        // R3 error bits on middle beats only
        send_pkt(3, EW'(7), 6'd0, 1'b1); idle(3);
        check_stats("R3 mid noise");

        // R6 clear with bit0 low does nothing
        reg_write(R_START, 16'h0000);
        check_stats("R6 no clear");
        // R6 clear
        reg_write(R_START, 16'h0001);
        exp_all = 0; exp_ok = 0; exp_bad = 0; exp_bytes = '0; exp_cause = '0;
        check_stats("R6 clear");
        check("R6 lpbk kept", 32'(lpbk_en), 32'd1);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [5:0] er;
            er = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
            send_pkt(1 + $urandom % 4, EW'($urandom), er, 1'b1);
            if ($urandom % 3 == 0) idle(1 + $urandom % 2);
            if ($urandom % 8 == 0) begin
                beat(1'b0, 1'($urandom), EW'($urandom), 6'h3F);
                idle(1);
            end
        end
        idle(3);
        check_stats("R11 random");

        // R7 captured high half stays frozen across a carry
        reg_read(R_BLO, d); check("R7 lo before", 32'(d), 32'(exp_bytes[15:0]));
        hi_old = exp_bytes[31:16];
        send_pkt(1025, EW'(0), 6'd0, 1'b0); idle(3);
        reg_read(R_BHI, d); check("R7 hi frozen", 32'(d), 32'(hi_old));
        check("R7 carry happened", 32'(exp_bytes[31:16] != hi_old), 32'd1);
        reg_read(R_BLO, d); check("R7 lo after", 32'(d), 32'(exp_bytes[15:0]));
        reg_read(R_BHI, d); check("R7 hi after", 32'(d), 32'(exp_bytes[31:16]));

        finish_run();
    end

endmodule